// File: doc/BRIEF.md
# Calibration Table Linear Interpolator

This block turns a raw code from an on-die temperature sensor into a signed temperature in millidegrees Celsius. The code-to-temperature curve is stored as a fixed table of 34 points. Each point pairs a raw code with a temperature. Between two points the curve is treated as a straight line. The raw column may rise or fall with temperature, and the block works out which way it runs from the first two points.

A conversion begins when `start` is high while the block is idle. The block first checks the code against the two ends of the table and clamps it if it falls outside them. Otherwise it walks through the table one point per clock. A code that lands exactly on a stored point returns that point's temperature at once. A code that lies strictly between two points is computed from a signed product followed by a multi-cycle signed division that truncates toward zero. `done` pulses for one cycle with the result on `temp_out`. `busy` stays high while a conversion is in progress, and any start request during that time is dropped.

Top module: `cal_interp`

## Requirements
- R1: Table entry i (i = 0..33) holds temperature -40000 + 5000*i. With ASCENDING=1 its raw code is 400 + 8*i + floor(i*i/8). With ASCENDING=0 it is 3800 - 9*i - floor(i*i/16).
- R2: The table counts as descending when raw code 0 is greater than raw code 1, and as ascending otherwise. The clamp and search rules of that direction are then applied.
- R3: In an ascending table, a code at or below raw code 0 returns -40000, and a code at or above raw code 33 returns 125000.
- R4: In a descending table, a code at or above raw code 0 returns -40000, and a code at or below raw code 33 returns 125000.
- R5: A code equal to the raw code of an interior entry returns that entry's temperature exactly.
- R6: A code strictly between entries a=i-1 and b=i returns temp_a + ((temp_a - temp_b)*(raw - raw_a)) / (raw_a - raw_b), using signed arithmetic and division truncated toward zero.
- R7: Each accepted request produces exactly one `done` pulse, one cycle long. `busy` is high from the cycle after the accepting edge until the `done` cycle, and is low in the `done` cycle.
- R8: A `start` that arrives while `busy` is high has no effect. It produces no result, and the result of the running conversion is unchanged.
- R9: After reset, `busy`, `done` and `temp_out` are all 0.
- R10: The search examines one entry per clock, starting at entry 1. A clamped code raises `done` in the cycle right after the accepting edge. An exact match at interior entry k raises `done` k cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a conversion of `raw_in`; honoured only when idle |
| raw_in | input | RAW_W | Raw sensor code, unsigned |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse; `temp_out` holds a new result |
| temp_out | output | TEMP_W | Signed temperature in millidegrees |

## Verification
Every code from just below to just above the table's range is converted, for both an ascending and a descending instance. This sweep reaches both clamp regions, every exact hit and every interpolated gap, and it separates the direction-specific clamp and search rules from one another. Exact hits and clamps also have their latency checked, which confirms that the walk advances one entry per clock. A start request injected in the middle of an interpolation shows that the request is dropped: exactly one pulse must follow, carrying the original result.

// File: rtl/cal_interp_pkg.sv
package cal_interp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_MULT,
    ST_DIV
  } state_t;

  // Raw code of entry i when the raw column rises with temperature
  function automatic int rise_code(input int i);
    return 400 + 8 * i + (i * i) / 8;
  endfunction

  // Raw code of entry i when the raw column falls with temperature
  function automatic int fall_code(input int i);
    return 3800 - 9 * i - (i * i) / 16;
  endfunction

  // Temperature of entry i in millidegrees
  function automatic int point_temp(input int i);
    return -40000 + 5000 * i;
  endfunction

endpackage

// File: rtl/cal_table_rom.sv
module cal_table_rom #(
  parameter int N_ENTRIES = 34,
  parameter int RAW_W     = 12,
  parameter int TEMP_W    = 20,
  parameter int ASCENDING = 1,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic [IDX_W-1:0]         idx,
  output logic [RAW_W-1:0]         cur_raw,
  output logic signed [TEMP_W-1:0] cur_temp,
  output logic [RAW_W-1:0]         prev_raw,
  output logic signed [TEMP_W-1:0] prev_temp,
  output logic [RAW_W-1:0]         first_raw,
  output logic [RAW_W-1:0]         second_raw,
  output logic [RAW_W-1:0]         last_raw,
  output logic signed [TEMP_W-1:0] first_temp,
  output logic signed [TEMP_W-1:0] last_temp
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

  logic [RAW_W-1:0]         raw_tab  [N_ENTRIES];
  logic signed [TEMP_W-1:0] temp_tab [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    if (ASCENDING != 0) begin : g_rise
      assign raw_tab[g] = RAW_W'(cal_interp_pkg::rise_code(g));
    end else begin : g_fall
      assign raw_tab[g] = RAW_W'(cal_interp_pkg::fall_code(g));
    end
    assign temp_tab[g] = TEMP_W'(cal_interp_pkg::point_temp(g));
  end

  logic [IDX_W-1:0] cur_i, prev_i;
  assign cur_i  = (idx > LAST_IDX) ? LAST_IDX : idx;
  assign prev_i = (cur_i == '0) ? '0 : cur_i - IDX_W'(1);

  assign cur_raw    = raw_tab[cur_i];
  assign cur_temp   = temp_tab[cur_i];
  assign prev_raw   = raw_tab[prev_i];
  assign prev_temp  = temp_tab[prev_i];
  assign first_raw  = raw_tab[0];
  assign second_raw = raw_tab[1];
  assign last_raw   = raw_tab[N_ENTRIES-1];
  assign first_temp = temp_tab[0];
  assign last_temp  = temp_tab[N_ENTRIES-1];

endmodule

// File: rtl/cal_div.sv
module cal_div #(
  parameter int W     = 34,
  parameter int OUT_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [W-1:0]     num,
  input  logic signed [W-1:0]     den,
  output logic                    busy,
  output logic                    done,
  output logic signed [OUT_W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  function automatic logic [W-1:0] magnitude(input logic signed [W-1:0] v);
    return v[W-1] ? $unsigned(-v) : $unsigned(v);
  endfunction

  logic          run;
  logic [CW-1:0] cnt;
  logic [W-1:0]  dvd, dmag, q;
  logic [W:0]    rem;
  logic          neg;

  logic [W:0]    rem_sh, trial;
  logic          fits;

  always_comb begin
    rem_sh = {rem[W-1:0], dvd[W-1]};
    trial  = rem_sh - {1'b0, dmag};
    fits   = ~trial[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      dvd  <= '0;
      dmag <= '0;
      q    <= '0;
      rem  <= '0;
      neg  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !run) begin
        run  <= 1'b1;
        cnt  <= CW'(W);
        dvd  <= magnitude(num);
        dmag <= magnitude(den);
        q    <= '0;
        rem  <= '0;
        neg  <= num[W-1] ^ den[W-1];
      end else if (run) begin
        dvd <= {dvd[W-2:0], 1'b0};
        q   <= {q[W-2:0], fits};
        rem <= fits ? trial : rem_sh;
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign busy = run;
  assign quo  = OUT_W'(neg ? -$signed(q) : $signed(q));

  // R6
  div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> den != '0);

  // R6
  div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rem < {1'b0, dmag});

endmodule

// File: rtl/cal_interp.sv
module cal_interp #(
  parameter int N_ENTRIES = 34,
  parameter int RAW_W     = 12,
  parameter int TEMP_W    = 20,
  parameter int ASCENDING = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [RAW_W-1:0]         raw_in,
  output logic                     busy,
  output logic                     done,
  output logic signed [TEMP_W-1:0] temp_out
);
  import cal_interp_pkg::*;

  localparam int IDX_W  = $clog2(N_ENTRIES);
  localparam int PROD_W = TEMP_W + RAW_W + 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

  // Numerator of the interpolation: (ta - tb) * (r - ra)
  function automatic logic signed [PROD_W-1:0] interp_num(
    input logic signed [TEMP_W-1:0] ta,
    input logic signed [TEMP_W-1:0] tb,
    input logic [RAW_W-1:0]         r,
    input logic [RAW_W-1:0]         ra);
    logic signed [PROD_W-1:0] dt, dr;
    dt = PROD_W'(ta) - PROD_W'(tb);
    dr = $signed(PROD_W'(r)) - $signed(PROD_W'(ra));
    return dt * dr;
  endfunction

  // Denominator of the interpolation: ra - rb
  function automatic logic signed [PROD_W-1:0] interp_den(
    input logic [RAW_W-1:0] ra,
    input logic [RAW_W-1:0] rb);
    return $signed(PROD_W'(ra)) - $signed(PROD_W'(rb));
  endfunction

  state_t                   state;
  logic [RAW_W-1:0]         raw_q;
  logic [IDX_W-1:0]         idx;
  logic [RAW_W-1:0]         a_raw, b_raw;
  logic signed [TEMP_W-1:0] a_temp, b_temp;

  logic [RAW_W-1:0]         cur_raw, prev_raw, first_raw, second_raw, last_raw;
  logic signed [TEMP_W-1:0] cur_temp, prev_temp, first_temp, last_temp;

  cal_table_rom #(
    .N_ENTRIES (N_ENTRIES),
    .RAW_W     (RAW_W),
    .TEMP_W    (TEMP_W),
    .ASCENDING (ASCENDING),
    .IDX_W     (IDX_W)
  ) u_rom (
    .idx        (idx),
    .cur_raw    (cur_raw),
    .cur_temp   (cur_temp),
    .prev_raw   (prev_raw),
    .prev_temp  (prev_temp),
    .first_raw  (first_raw),
    .second_raw (second_raw),
    .last_raw   (last_raw),
    .first_temp (first_temp),
    .last_temp  (last_temp)
  );

  // Named events used by the control logic and the assertions
  logic desc_tab, accept, clamp_lo_hit, clamp_hi_hit;
  logic in_search, match_hit, past_hit, bracket_hit;
  logic div_start, div_busy, div_done;
  logic signed [TEMP_W-1:0] div_quo;

  assign desc_tab     = first_raw > second_raw;
  assign accept       = start && (state == ST_IDLE);
  assign clamp_lo_hit = desc_tab ? (raw_in >= first_raw) : (raw_in <= first_raw);
  assign clamp_hi_hit = desc_tab ? (raw_in <= last_raw)  : (raw_in >= last_raw);
  assign in_search    = state == ST_SEARCH;
  assign match_hit    = in_search && (raw_q == cur_raw);
  assign past_hit     = in_search && !match_hit &&
                        (desc_tab ? (raw_q > cur_raw) : (raw_q < cur_raw));
  assign bracket_hit  = past_hit || (in_search && !match_hit && idx == LAST_IDX);
  assign div_start    = state == ST_MULT;

  cal_div #(
    .W     (PROD_W),
    .OUT_W (TEMP_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (interp_num(a_temp, b_temp, raw_q, a_raw)),
    .den   (interp_den(a_raw, b_raw)),
    .busy  (div_busy),
    .done  (div_done),
    .quo   (div_quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      raw_q    <= '0;
      idx      <= '0;
      a_raw    <= '0;
      b_raw    <= '0;
      a_temp   <= '0;
      b_temp   <= '0;
      temp_out <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            raw_q <= raw_in;
            if (clamp_lo_hit) begin
              temp_out <= first_temp;
              done     <= 1'b1;
            end else if (clamp_hi_hit) begin
              temp_out <= last_temp;
              done     <= 1'b1;
            end else begin
              idx   <= IDX_W'(1);
              state <= ST_SEARCH;
            end
          end
        end
        ST_SEARCH: begin
          if (match_hit) begin
            temp_out <= cur_temp;
            done     <= 1'b1;
            state    <= ST_IDLE;
          end else if (bracket_hit) begin
            a_raw  <= prev_raw;
            a_temp <= prev_temp;
            b_raw  <= cur_raw;
            b_temp <= cur_temp;
            state  <= ST_MULT;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        ST_MULT: state <= ST_DIV;
        ST_DIV: begin
          if (div_done) begin
            temp_out <= a_temp + div_quo;
            done     <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = state != ST_IDLE;

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(raw_q));

  // R10
  search_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_search && $past(state == ST_SEARCH)) |-> idx == $past(idx) + IDX_W'(1));

  // R10
  search_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_search |-> (idx >= IDX_W'(1)) && (idx <= LAST_IDX));

  // R5
  match_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |=> done && temp_out == $past(cur_temp));

  // R6
  result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (temp_out >= first_temp) && (temp_out <= last_temp));

  // R6
  div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |-> !div_busy);

endmodule

// File: tb/cal_interp_tb.sv
module cal_interp_tb;
  localparam int RAW_W  = 12;
  localparam int TEMP_W = 20;
  localparam int NPTS   = 34;

  typedef struct {
    int    temp;
    int    lat;
    int    c0;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_a = 1'b0, start_d = 1'b0;
  logic [RAW_W-1:0] raw_a = '0, raw_d = '0;
  logic busy_a, done_a, busy_d, done_d;
  logic signed [TEMP_W-1:0] temp_a, temp_d;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  exp_t qa[$];
  exp_t qd[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cal_interp #(.ASCENDING(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start_a), .raw_in(raw_a),
    .busy(busy_a), .done(done_a), .temp_out(temp_a));

  cal_interp #(.ASCENDING(0)) u_dut_desc (
    .clk(clk), .rst_n(rst_n), .start(start_d), .raw_in(raw_d),
    .busy(busy_d), .done(done_d), .temp_out(temp_d));

  function automatic int code_of(input int i, input bit dsc);
    if (dsc) return 3800 - 9 * i - (i * i) / 16;
    return 400 + 8 * i + (i * i) / 8;
  endfunction

  function automatic int deg_of(input int i);
    return 5000 * i - 40000;
  endfunction

  function automatic void expect_of(input int raw, input bit dsc,
                                    output int t, output int lat, output string tag);
    int r0 = code_of(0, dsc);
    int rl = code_of(NPTS - 1, dsc);
    lat = -1;
    tag = dsc ? "R4" : "R3";
    if ((!dsc && raw <= r0) || (dsc && raw >= r0)) begin
      t = deg_of(0); lat = 0; return;
    end
    if ((!dsc && raw >= rl) || (dsc && raw <= rl)) begin
      t = deg_of(NPTS - 1); lat = 0; return;
    end
    for (int i = 1; i < NPTS; i++) begin
      int rp = code_of(i - 1, dsc);
      int ri = code_of(i, dsc);
      if (raw == ri) begin
        t = deg_of(i); lat = i; tag = "R5"; return;
      end
      if ((raw > rp && raw < ri) || (raw < rp && raw > ri)) begin
        t = deg_of(i - 1) + ((deg_of(i - 1) - deg_of(i)) * (raw - rp)) / (rp - ri);
        tag = "R6"; return;
      end
    end
    t = 0; tag = "R6";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Driver: waits for the chosen instance to be idle, requests one conversion
  task automatic convert(input bit dsc, input int raw, input string tag);
    exp_t e;
    int t, l;
    string rt;
    while (dsc ? busy_d : busy_a) @(negedge clk);
    expect_of(raw, dsc, t, l, rt);
    if (dsc) begin start_d = 1'b1; raw_d = RAW_W'(raw); end
    else     begin start_a = 1'b1; raw_a = RAW_W'(raw); end
    @(posedge clk);
    #1;
    e.temp = t; e.lat = l; e.c0 = cyc;
    e.tag = (tag == "") ? rt : {tag, " ", rt};
    if (dsc) qd.push_back(e); else qa.push_back(e);
    @(negedge clk);
    start_a = 1'b0;
    start_d = 1'b0;
  endtask

  // Monitors: pop one expected item per done pulse
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && done_a) begin
      if (qa.size() == 0) check("R7 extra done (asc)", 1, 0);
      else begin
        e = qa.pop_front();
        check({e.tag, " asc temp"}, int'(temp_a), e.temp);
        if (e.lat >= 0) check({e.tag, " R10 asc latency"}, cyc - e.c0, e.lat);
      end
    end
  end

  always @(negedge clk) begin
    exp_t e;
    if (rst_n && done_d) begin
      if (qd.size() == 0) check("R7 extra done (desc)", 1, 0);
      else begin
        e = qd.pop_front();
        check({e.tag, " desc temp"}, int'(temp_d), e.temp);
        if (e.lat >= 0) check({e.tag, " R10 desc latency"}, cyc - e.c0, e.lat);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    int t, l;
    string s;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 busy asc", int'(busy_a), 0);
    check("R9 done asc", int'(done_a), 0);
    check("R9 temp asc", int'(temp_a), 0);
    check("R9 busy desc", int'(busy_d), 0);
    check("R9 temp desc", int'(temp_d), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: direction taken from the table; the same code clamps to opposite ends
    convert(0, 4000, "R2");
    convert(1, 4000, "R2");
    convert(0, 100, "R2");
    convert(1, 100, "R2");
    // R1 R10: exact interior hits, latency equal to the entry index
    convert(0, 443, "R1");
    convert(1, 3595, "R1");
    convert(0, code_of(1, 0), "R1");
    convert(1, code_of(NPTS - 2, 1), "R1");

    // R8 R7: start while busy is dropped
    while (busy_a) @(negedge clk);
    @(negedge clk);
    convert(0, 445, "R8");
    repeat (3) @(negedge clk);
    check("R7 busy during conversion", int'(busy_a), 1);
    start_a = 1'b1; raw_a = RAW_W'(0);
    @(negedge clk);
    start_a = 1'b0;
    while (!done_a) @(negedge clk);
    expect_of(445, 0, t, l, s);
    @(negedge clk);
    check("R7 single done pulse", int'(done_a), 0);
    check("R7 idle after done", int'(busy_a), 0);
    repeat (5) @(negedge clk);
    check("R8 no result for dropped start", qa.size(), 0);
    check("R8 result kept", int'(temp_a), t);

    // R3 R5 R6: full sweep of the ascending instance
    for (int r = 390; r <= 810; r++) convert(0, r, "");
    // R4 R5 R6: full sweep of the descending instance
    for (int r = 3425; r <= 3810; r++) convert(1, r, "");

    repeat (100) @(negedge clk);
    check("R7 all asc results seen", qa.size(), 0);
    check("R7 all desc results seen", qd.size(), 0);
    summary();
  end

endmodule